// File: doc/BRIEF.md
# Checkpoint Generation Ring with Latency-Gated Recycling

This block keeps a small ring of dependence-register sets, one per outstanding checkpoint, for a processor that tracks which other processors it has exchanged data with. Each checkpoint strobe opens a new set, which becomes the active set. Dependence events from the coherence logic then mark a bit per processor, in a producer map or a consumer map, inside the active set. A checkpoint is trusted as a rollback target only once the fault-detection latency `DET_LAT` has elapsed since it was taken. The elapsed time is measured against a free-running cycle counter that is supplied on `now_i`.

A set is recycled only when the checkpoint that follows it has itself become safe, because no fault can then send execution back past it. If every set is in use when a checkpoint is requested, the block holds the request and raises a stall until a set is released. A fault strobe rolls the ring back: the newest safe checkpoint becomes the active set, its dependence maps are cleared, every newer set is discarded, and any held request is dropped.

Top module: `ckpt_gen_ring`

## Requirements
- R1: After reset the active index is 0, the safe index is 0, stall is low and both dependence maps of the active set are zero; set 0 counts as a safe checkpoint from reset on.
- R2: A checkpoint strobe with a free set (and no fault) moves the active index to (index + 1) mod NSETS in the next cycle, and the new active set starts with both maps zero.
- R3: A dependence event with kind 0 sets bit `dep_proc_i` of the producer map, and kind 1 sets that bit of the consumer map, of the active set; the bit is visible from the next cycle and bits accumulate.
- R4: The safe index is the newest live checkpoint whose strobe was sampled with counter value T such that now_i - T >= DET_LAT, evaluated in the current cycle; until then an older checkpoint is reported.
- R5: The oldest live set is freed at the clock edge that ends the first cycle in which its successor is safe; at most NSETS sets are live.
- R6: A checkpoint requested while NSETS sets are live drives stall high in that cycle and holds it high, without a new strobe, until the held request is taken in the cycle after a release, in which stall is low; the active index advances one cycle later.
- R7: A fault makes the next-cycle active index equal to the safe index of the fault cycle, clears both maps of that set, frees every newer set (so checkpoints are again accepted without stall) and drops a held request.
- R8: In a fault cycle a checkpoint strobe and a dependence event are ignored and stall is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ckpt_i | input | 1 | Checkpoint request strobe |
| fault_i | input | 1 | Fault strobe, starts a rollback |
| now_i | input | TSW | Free-running cycle counter |
| dep_vld_i | input | 1 | Dependence event valid |
| dep_kind_i | input | 1 | 0: producer map, 1: consumer map |
| dep_proc_i | input | $clog2(NPROC) | Processor number of the event |
| act_idx_o | output | $clog2(NSETS) | Set receiving dependence records |
| safe_idx_o | output | $clog2(NSETS) | Newest safe checkpoint set |
| stall_o | output | 1 | Checkpoint request waiting for a free set |
| act_prod_o | output | NPROC | Producer map of the active set |
| act_cons_o | output | NPROC | Consumer map of the active set |

## Verification
The hardest state to reach is a fault that arrives while the ring is full and a request is held, since it needs several checkpoints taken inside one detection window. The stimulus fires a burst of back-to-back strobes just after a rollback so that all newer sets are still unsafe, and then strikes a fault while the stall is up. The checks then confirm that a fresh strobe is taken without stall. A second burst is timed against the supplied counter so that the held request is released at the exact edge where the successor set matures.

// File: rtl/ckr_pkg.sv
package ckr_pkg;

  typedef enum logic {
    REC_PROD = 1'b0,
    REC_CONS = 1'b1
  } rec_kind_e;

  // ring successor of a set index
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // number of steps from 'from' forward to 'to' around the ring
  function automatic int unsigned ring_dist(int unsigned from, int unsigned to, int unsigned n);
    return (to + n - from) % n;
  endfunction

endpackage

// File: rtl/ckr_slot.sv
module ckr_slot #(
  parameter int TSW     = 16,
  parameter int NPROC   = 8,
  parameter int DET_LAT = 20,
  parameter bit IS_BASE = 1'b0,
  localparam int PW     = $clog2(NPROC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TSW-1:0]   now_i,
  input  logic             clr_i,
  input  logic             wipe_i,
  input  logic             rec_en_i,
  input  logic             rec_kind_i,
  input  logic [PW-1:0]    rec_proc_i,
  output logic             safe_o,
  output logic [NPROC-1:0] prod_o,
  output logic [NPROC-1:0] cons_o
);
  import ckr_pkg::*;

  localparam logic [TSW-1:0] LAT_T = TSW'(DET_LAT);

  logic [TSW-1:0]   ts_q;
  logic             safe_q;
  logic [TSW-1:0]   age;
  logic [NPROC-1:0] prod_q, cons_q;

  // modular age; the sticky flag survives counter wrap
  always_comb begin
    age    = now_i - ts_q;
    safe_o = safe_q | (age >= LAT_T);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_q   <= '0;
      safe_q <= IS_BASE;
      prod_q <= '0;
      cons_q <= '0;
    end else if (clr_i) begin
      ts_q   <= now_i;
      safe_q <= 1'b0;
      prod_q <= '0;
      cons_q <= '0;
    end else begin
      safe_q <= safe_o;
      if (wipe_i) begin
        prod_q <= '0;
        cons_q <= '0;
      end else if (rec_en_i) begin
        if (rec_kind_i == REC_CONS) cons_q[rec_proc_i] <= 1'b1;
        else                        prod_q[rec_proc_i] <= 1'b1;
      end
    end
  end

  assign prod_o = prod_q;
  assign cons_o = cons_q;

endmodule

// File: rtl/ckr_ctl.sv
module ckr_ctl #(
  parameter int NSETS = 4,
  localparam int IW   = $clog2(NSETS),
  localparam int LW   = $clog2(NSETS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ckpt_i,
  input  logic             fault_i,
  input  logic [NSETS-1:0] safe_vec_i,
  input  logic [IW-1:0]    pick_i,
  output logic [IW-1:0]    head_o,
  output logic [IW-1:0]    tail_o,
  output logic [LW-1:0]    live_o,
  output logic             take_o,
  output logic             rel_o,
  output logic             stall_o
);
  import ckr_pkg::*;

  logic [IW-1:0] head_q, tail_q, succ;
  logic [LW-1:0] live_q;
  logic          pend_q, want, full;

  always_comb begin
    succ    = IW'(wrap_inc(int'(tail_q), NSETS));
    want    = ckpt_i | pend_q;
    full    = (live_q == LW'(NSETS));
    take_o  = !fault_i && want && !full;
    stall_o = !fault_i && want && full;
    rel_o   = !fault_i && (tail_q != head_q) && safe_vec_i[succ];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      live_q <= LW'(1);
      pend_q <= 1'b0;
    end else if (fault_i) begin
      head_q <= pick_i;
      live_q <= LW'(ring_dist(int'(tail_q), int'(pick_i), NSETS) + 1);
      pend_q <= 1'b0;
    end else begin
      if (take_o) head_q <= IW'(wrap_inc(int'(head_q), NSETS));
      if (rel_o)  tail_q <= succ;
      live_q <= live_q + LW'(take_o) - LW'(rel_o);
      pend_q <= stall_o;
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign live_o = live_q;

endmodule

// File: rtl/ckpt_gen_ring.sv
module ckpt_gen_ring #(
  parameter int NSETS   = 4,
  parameter int DET_LAT = 20,
  parameter int NPROC   = 8,
  parameter int TSW     = 16,
  localparam int IW     = $clog2(NSETS),
  localparam int LW     = $clog2(NSETS + 1),
  localparam int PW     = $clog2(NPROC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ckpt_i,
  input  logic             fault_i,
  input  logic [TSW-1:0]   now_i,
  input  logic             dep_vld_i,
  input  logic             dep_kind_i,
  input  logic [PW-1:0]    dep_proc_i,
  output logic [IW-1:0]    act_idx_o,
  output logic [IW-1:0]    safe_idx_o,
  output logic             stall_o,
  output logic [NPROC-1:0] act_prod_o,
  output logic [NPROC-1:0] act_cons_o
);
  import ckr_pkg::*;

  logic [IW-1:0]    head, tail, pick, nxt_head;
  logic [LW-1:0]    live_cnt;
  logic             take, rel;
  logic [NSETS-1:0] safe_vec, clr_vec, wipe_vec, rec_vec;
  logic [NPROC-1:0] prod_arr [NSETS];
  logic [NPROC-1:0] cons_arr [NSETS];

  ckr_ctl #(.NSETS(NSETS)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ckpt_i     (ckpt_i),
    .fault_i    (fault_i),
    .safe_vec_i (safe_vec),
    .pick_i     (pick),
    .head_o     (head),
    .tail_o     (tail),
    .live_o     (live_cnt),
    .take_o     (take),
    .rel_o      (rel),
    .stall_o    (stall_o)
  );

  assign nxt_head = IW'(wrap_inc(int'(head), NSETS));

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    assign clr_vec[g]  = take && (nxt_head == IW'(g));
    assign wipe_vec[g] = fault_i && (pick == IW'(g));
    assign rec_vec[g]  = dep_vld_i && !fault_i && (head == IW'(g));

    ckr_slot #(
      .TSW     (TSW),
      .NPROC   (NPROC),
      .DET_LAT (DET_LAT),
      .IS_BASE (g == 0)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .now_i      (now_i),
      .clr_i      (clr_vec[g]),
      .wipe_i     (wipe_vec[g]),
      .rec_en_i   (rec_vec[g]),
      .rec_kind_i (dep_kind_i),
      .rec_proc_i (dep_proc_i),
      .safe_o     (safe_vec[g]),
      .prod_o     (prod_arr[g]),
      .cons_o     (cons_arr[g])
    );
  end

  // newest safe live set: walk backward from the head
  always_comb begin
    logic found;
    logic [IW-1:0] idx;
    pick  = tail;
    found = 1'b0;
    for (int k = 0; k < NSETS; k++) begin
      idx = IW'((int'(head) + NSETS - k) % NSETS);
      if (!found && (k < int'(live_cnt)) && safe_vec[idx]) begin
        pick  = idx;
        found = 1'b1;
      end
    end
  end

  assign act_idx_o  = head;
  assign safe_idx_o = pick;
  assign act_prod_o = prod_arr[head];
  assign act_cons_o = cons_arr[head];

endmodule

// File: rtl/ckr_chk.sv
module ckr_chk #(
  parameter int NSETS = 4,
  parameter int NPROC = 8,
  localparam int IW   = $clog2(NSETS),
  localparam int LW   = $clog2(NSETS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ckpt_i,
  input logic             fault_i,
  input logic             stall_o,
  input logic [IW-1:0]    act_idx_o,
  input logic [IW-1:0]    safe_idx_o,
  input logic [NPROC-1:0] act_prod_o,
  input logic [NPROC-1:0] act_cons_o,
  input logic [LW-1:0]    live_i,
  input logic [NSETS-1:0] safe_i
);
  import ckr_pkg::*;

  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (ckpt_i && !fault_i && !stall_o) |=>
      act_idx_o == IW'(wrap_inc(int'($past(act_idx_o)), NSETS)));

  a_r4_pick_safe: assert property (@(posedge clk) disable iff (!rst_n)
    safe_i[safe_idx_o]);

  a_r5_live_range: assert property (@(posedge clk) disable iff (!rst_n)
    (live_i != '0) && (live_i <= LW'(NSETS)));

  a_r6_stall_full: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> live_i == LW'(NSETS));

  a_r7_fault_target: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> act_idx_o == $past(safe_idx_o));

  a_r7_fault_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> (act_prod_o == '0) && (act_cons_o == '0));

  a_r8_no_stall_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |-> !stall_o);

endmodule

bind ckpt_gen_ring ckr_chk #(.NSETS(NSETS), .NPROC(NPROC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ckpt_i     (ckpt_i),
  .fault_i    (fault_i),
  .stall_o    (stall_o),
  .act_idx_o  (act_idx_o),
  .safe_idx_o (safe_idx_o),
  .act_prod_o (act_prod_o),
  .act_cons_o (act_cons_o),
  .live_i     (live_cnt),
  .safe_i     (safe_vec)
);

// File: tb/tb_ckpt_gen_ring.sv
`timescale 1ns/1ps
module tb_ckpt_gen_ring;
  localparam int NSETS = 4;
  localparam int LAT   = 20;
  localparam int NPROC = 8;
  localparam int TSW   = 16;

  localparam int S_ACT = 0, S_SAFE = 1, S_STALL = 2, S_PROD = 3, S_CONS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ckpt = 1'b0, fault = 1'b0, dvld = 1'b0, dkind = 1'b0;
  logic [2:0] dproc = '0;
  logic [TSW-1:0] now;
  logic [1:0] act_idx, safe_idx;
  logic stall;
  logic [NPROC-1:0] prod, cons;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  typedef struct {
    int    at;
    int    sel;
    int    exp;
    string req;
  } item_t;
  item_t sbq[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign now = TSW'(cyc);

  ckpt_gen_ring #(.NSETS(NSETS), .DET_LAT(LAT), .NPROC(NPROC), .TSW(TSW)) dut (
    .clk(clk), .rst_n(rst_n), .ckpt_i(ckpt), .fault_i(fault), .now_i(now),
    .dep_vld_i(dvld), .dep_kind_i(dkind), .dep_proc_i(dproc),
    .act_idx_o(act_idx), .safe_idx_o(safe_idx), .stall_o(stall),
    .act_prod_o(prod), .act_cons_o(cons)
  );

  function automatic int obs(int sel);
    case (sel)
      S_ACT:   return int'(act_idx);
      S_SAFE:  return int'(safe_idx);
      S_STALL: return int'(stall);
      S_PROD:  return int'(prod);
      default: return int'(cons);
    endcase
  endfunction

  // monitor: compare queued expectations in their cycle
  always @(negedge clk) begin
    item_t it;
    int    got;
    #2;
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      it  = sbq.pop_front();
      got = obs(it.sel);
      n_chk++;
      if (it.at != cyc || got != it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d cycle=%0d actual=%0d expected=%0d",
                 it.req, it.sel, cyc, got, it.exp);
      end
    end
  end

  task automatic drive(bit c, bit f, bit dv, bit dk, int dp);
    @(negedge clk);
    ckpt = c; fault = f; dvld = dv; dkind = dk; dproc = 3'(dp);
  endtask

  task automatic expect_v(int ahead, int sel, int exp, string req);
    item_t it;
    it.at = cyc + ahead; it.sel = sel; it.exp = exp; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic idle_until(int t);
    while (cyc < t) drive(0, 0, 0, 0, 0);
  endtask

  initial begin
    int t1, a, f, g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    drive(0, 0, 0, 0, 0);
    expect_v(0, S_ACT, 0, "R1"); expect_v(0, S_SAFE, 0, "R1");
    expect_v(0, S_STALL, 0, "R1"); expect_v(0, S_PROD, 0, "R1");
    expect_v(0, S_CONS, 0, "R1");

    drive(0, 0, 1, 0, 3);
    expect_v(1, S_PROD, 8'h08, "R3");
    drive(0, 0, 1, 1, 5);
    expect_v(1, S_PROD, 8'h08, "R3"); expect_v(1, S_CONS, 8'h20, "R3");

    drive(1, 0, 0, 0, 0); t1 = cyc;
    expect_v(1, S_ACT, 1, "R2"); expect_v(1, S_PROD, 0, "R2");
    expect_v(1, S_CONS, 0, "R2"); expect_v(1, S_SAFE, 0, "R4");

    idle_until(t1 + LAT - 1); expect_v(0, S_SAFE, 0, "R4");
    idle_until(t1 + LAT);     expect_v(0, S_SAFE, 1, "R4");

    drive(1, 0, 0, 0, 0); a = cyc; expect_v(1, S_ACT, 2, "R2");
    drive(1, 0, 0, 0, 0);          expect_v(1, S_ACT, 3, "R2");
    drive(1, 0, 0, 0, 0);          expect_v(1, S_ACT, 0, "R2");
    drive(1, 0, 0, 0, 0);          expect_v(0, S_STALL, 1, "R6");
    drive(0, 0, 0, 0, 0);          expect_v(0, S_STALL, 1, "R6");
    idle_until(a + LAT - 1); expect_v(0, S_SAFE, 1, "R4");
    idle_until(a + LAT);
    expect_v(0, S_STALL, 1, "R5"); expect_v(0, S_SAFE, 2, "R4");
    drive(0, 0, 0, 0, 0);
    expect_v(0, S_STALL, 0, "R6"); expect_v(0, S_ACT, 0, "R6");
    expect_v(0, S_SAFE, 3, "R4");  expect_v(1, S_ACT, 1, "R6");

    drive(0, 0, 1, 0, 6);
    expect_v(0, S_SAFE, 0, "R4"); expect_v(1, S_PROD, 8'h40, "R3");

    drive(1, 1, 1, 1, 2); f = cyc;
    expect_v(0, S_SAFE, 0, "R7"); expect_v(0, S_STALL, 0, "R8");
    expect_v(1, S_ACT, 0, "R7");  expect_v(1, S_PROD, 0, "R7");
    expect_v(1, S_CONS, 0, "R8");
    drive(0, 0, 0, 0, 0);
    expect_v(1, S_ACT, 0, "R8");

    drive(1, 0, 0, 0, 0); g = cyc; expect_v(1, S_ACT, 1, "R2");
    drive(1, 0, 0, 0, 0);          expect_v(1, S_ACT, 2, "R2");
    drive(1, 0, 0, 0, 0);          expect_v(1, S_ACT, 3, "R2");
    drive(1, 0, 0, 0, 0);
    expect_v(0, S_STALL, 1, "R6"); expect_v(0, S_SAFE, 0, "R4");
    drive(0, 1, 0, 0, 0);
    expect_v(0, S_STALL, 0, "R8"); expect_v(1, S_ACT, 0, "R7");
    drive(1, 0, 0, 0, 0);
    expect_v(0, S_STALL, 0, "R7"); expect_v(0, S_SAFE, 0, "R7");
    expect_v(1, S_ACT, 1, "R7");
    drive(0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    #5;
    if (f == 0 || g == 0) n_fail++;
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      n_chk++; n_fail++;
      $display("FAIL %s sel=%0d never sampled actual=none expected=%0d", it.req, it.sel, it.exp);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule